// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by walking a table hierarchy held in memory. The walk starts with a context table that is indexed by the current context number. It then passes through up to three further table levels. Each level is fetched with one 32-bit read over a simple request/response memory port, and only one read is in flight at any time. The walk stops at the first page entry it finds, so a leaf at the first level maps a 16 MB region, a leaf at the second level maps a 256 KB region, and a leaf at the third level maps a 4 KB page. A missing mapping or a malformed entry ends the walk with an error code that holds both the level and the cause.

When a leaf is found, the walker checks the entry's referenced bit and, for stores, its modified bit. If a bit it needs is clear, the walker sets it and writes the entry back to the address it was read from before it reports the result. When translation is switched off, no table is read: the address passes straight through. In boot mode, instruction fetches are redirected into a boot ROM window instead. A client starts a walk by pulsing a request while the walker is idle, then waits for a one-cycle done pulse that carries every result at once.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `done` and `memReq` are low until a request is accepted.
- R2: A request is accepted only while the walker is idle. A `reqValid` seen during a walk is ignored. Each accepted request gives exactly one single-cycle `done` pulse, and all result outputs are valid in that cycle.
- R3: At most one memory read is outstanding. The next memory access is issued only after `memRvalid` has returned the previous read.
- R4: The first read of a walk goes to the context entry at ((ctxTblPtr & ~63) << 4) + ctxNum*4.
- R5: The three level entry addresses are ((entry & ~3) << 4) plus an index, where entry is the entry fetched at the level before. The index is va[31:24]*4 at level 1, va[23:18]*4 at level 2 and va[17:12]*4 at level 3.
- R6: The entry type is held in bits [1:0]: 0 invalid, 1 pointer, 2 page, 3 reserved. A pointer at the context level or at levels 1 and 2 makes the walker fetch the next level.
- R7: A page entry found at level 1, 2 or 3 ends the walk. `paddr` = ((entry & 0xFFFFFF00) << 4) + va[23:0], va[17:0] or va[11:0] respectively, and `pte` is the leaf entry.
- R8: `errCode` = (level << 8) | (cause << 2). Cause 1 means invalid and cause 4 means a translation error. Reserved entries give cause 4. A page entry at the context level gives level 0, cause 4. A pointer entry at level 3 gives level 3, cause 4.
- R9: The referenced bit is bit 5 and the modified bit is bit 6. `reqKind` is encoded as 0 load, 1 store, 2 fetch. If the referenced bit is clear, or the access is a store and the modified bit is clear, the walker writes the entry back with bit 5 set, and with bit 6 also set for a store. The write goes to the leaf entry's address, and `pte` shows the updated value.
- R10: If no bit needs setting, no memory write is issued and `pte` equals the entry as read.
- R11: With `xlatEn` low, no memory access takes place, `paddr` = zero-extended va, `prot` = 3'b111 (bit 2 read, bit 1 write, bit 0 execute), `pte` = 0 and `errCode` = 0.
- R12: With `xlatEn` low and `bootMode` high, a fetch gets `paddr` = promBase | va[18:0] and `prot` = 3'b101. Loads and stores pass through as in R11.
- R13: On a walk error, `paddr`, `pte` and `prot` are zero. After a successful walk, `errCode` and `prot` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Start a translation (taken only when idle) |
| reqVa | input | 32 | Virtual address |
| reqKind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| ctxTblPtr | input | 32 | Context table pointer |
| ctxNum | input | CTX_W | Current context number |
| xlatEn | input | 1 | Translation enable |
| bootMode | input | 1 | Boot fetch redirection when translation is off |
| promBase | input | 36 | Base address of the boot ROM window |
| memReq | output | 1 | Memory access strobe, one cycle |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | 36 | Memory address |
| memWdata | output | 32 | Write data (updated leaf entry) |
| memRvalid | input | 1 | Read data is valid |
| memRdata | input | 32 | Read data |
| done | output | 1 | Result pulse, one cycle |
| pte | output | 32 | Leaf entry after any update |
| paddr | output | 36 | Physical address |
| errCode | output | 10 | Walk error code, zero on success |
| prot | output | 3 | Protection for pass-through: read, write, execute |

## Verification
The assertions check on every cycle that a single read is in flight, that `done` lasts one cycle, that every write-back goes to the last address read and carries a set referenced bit, and that an error result has well-formed fields with the other outputs cleared. Only the bench scenarios can show the correct entry addresses at each level, the physical address for each leaf size, the write-back decision across every combination of referenced bit, modified bit and access kind, and the exact error code for each level and entry type. The bench also covers the pass-through and boot redirection results, and confirms that a request arriving mid-walk leaves the running translation untouched.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int VA_W      = 32;
  localparam int PA_W      = 36;
  localparam int ENT_W     = 32;
  localparam int ERR_W     = 10;
  localparam int PROT_W    = 3;
  localparam int REF_BIT   = 5;
  localparam int MOD_BIT   = 6;
  localparam int L1_OFF_W  = 24;
  localparam int L2_OFF_W  = 18;
  localparam int PG_OFF_W  = 12;
  localparam int ROM_OFF_W = 19;
  localparam logic [VA_W-1:0]  CTX_ALIGN_MASK = ~VA_W'(63);
  localparam logic [ENT_W-1:0] PTR_MASK       = ~ENT_W'(3);
  localparam logic [ENT_W-1:0] PPN_MASK       = 32'hFFFF_FF00;

  typedef enum logic [1:0] {
    ET_INVALID = 2'd0,
    ET_PTR     = 2'd1,
    ET_PAGE    = 2'd2,
    ET_RSVD    = 2'd3
  } entType_e;

  typedef enum logic [1:0] {
    AK_LOAD  = 2'd0,
    AK_STORE = 2'd1,
    AK_FETCH = 2'd2,
    AK_SPARE = 2'd3
  } accKind_e;

  typedef enum logic [1:0] {
    RES_NONE, RES_BYPASS, RES_LEAF, RES_ERR
  } resKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       capture;
    logic       rdIssue;
    logic       wrIssue;
    logic       setBypass;
    logic       setLeaf;
    logic       setErr;
    logic       errTranslation;
    logic [1:0] lvl;
  } walkStrobe_t;
endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        xlatEn,
  input  logic [1:0]  rdType,
  input  logic        wbNeeded,
  input  logic        memRvalid,
  output walkStrobe_t strb,
  output logic        memReq,
  output logic        memWe,
  output logic        done
);
  typedef enum logic [2:0] {
    S_IDLE, S_CTX, S_L1, S_L2, S_L3, S_UPDATE, S_DONE
  } walkState_e;

  walkState_e stateQ, stateNxt, deeper;
  logic       rdPendQ, rdPendNxt;
  logic [1:0] curLvl;
  entType_e   et;

  assign et   = entType_e'(rdType);
  assign done = (stateQ == S_DONE);

  always_comb begin
    case (stateQ)
      S_L1:    curLvl = 2'd1;
      S_L2:    curLvl = 2'd2;
      S_L3:    curLvl = 2'd3;
      default: curLvl = 2'd0;
    endcase
  end

  always_comb begin
    case (stateQ)
      S_CTX:   deeper = S_L1;
      S_L1:    deeper = S_L2;
      default: deeper = S_L3;
    endcase
  end

  always_comb begin
    strb      = '0;
    strb.lvl  = curLvl;
    stateNxt  = stateQ;
    rdPendNxt = rdPendQ;
    memReq    = 1'b0;
    memWe     = 1'b0;
    case (stateQ)
      S_IDLE: begin
        if (reqValid) begin
          strb.capture = 1'b1;
          if (!xlatEn) begin
            strb.setBypass = 1'b1;
            stateNxt       = S_DONE;
          end else begin
            stateNxt = S_CTX;
          end
        end
      end
      S_CTX, S_L1, S_L2, S_L3: begin
        if (!rdPendQ) begin
          memReq       = 1'b1;
          strb.rdIssue = 1'b1;
          rdPendNxt    = 1'b1;
        end else if (memRvalid) begin
          rdPendNxt = 1'b0;
          case (et)
            ET_PTR: begin
              if (stateQ == S_L3) begin
                strb.setErr         = 1'b1;
                strb.errTranslation = 1'b1;
                stateNxt            = S_DONE;
              end else begin
                stateNxt = deeper;
              end
            end
            ET_PAGE: begin
              if (stateQ == S_CTX) begin
                strb.setErr         = 1'b1;
                strb.errTranslation = 1'b1;
                stateNxt            = S_DONE;
              end else begin
                strb.setLeaf = 1'b1;
                stateNxt     = wbNeeded ? S_UPDATE : S_DONE;
              end
            end
            ET_INVALID: begin
              strb.setErr = 1'b1;
              stateNxt    = S_DONE;
            end
            default: begin
              strb.setErr         = 1'b1;
              strb.errTranslation = 1'b1;
              stateNxt            = S_DONE;
            end
          endcase
        end
      end
      S_UPDATE: begin
        memReq       = 1'b1;
        memWe        = 1'b1;
        strb.wrIssue = 1'b1;
        stateNxt     = S_DONE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      rdPendQ <= 1'b0;
    end else begin
      stateQ  <= stateNxt;
      rdPendQ <= rdPendNxt;
    end
  end
endmodule

// File: rtl/pgwalk_dp.sv
module pgwalk_dp
  import pgwalk_pkg::*;
#(
  parameter int CTX_W = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strb,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [1:0]        reqKind,
  input  logic [VA_W-1:0]   ctxTblPtr,
  input  logic [CTX_W-1:0]  ctxNum,
  input  logic              bootMode,
  input  logic [PA_W-1:0]   promBase,
  input  logic              memRvalid,
  input  logic [ENT_W-1:0]  memRdata,
  output logic [PA_W-1:0]   memAddr,
  output logic [ENT_W-1:0]  memWdata,
  output logic [1:0]        rdType,
  output logic              wbNeeded,
  output logic [ENT_W-1:0]  pte,
  output logic [PA_W-1:0]   paddr,
  output logic [ERR_W-1:0]  errCode,
  output logic [PROT_W-1:0] prot
);
  logic [VA_W-1:0]  vaQ, ptrQ;
  logic [1:0]       kindQ, leafLvlQ;
  logic [CTX_W-1:0] ctxQ;
  logic             bootQ;
  logic [PA_W-1:0]  promQ, walkAddrQ;
  logic [ENT_W-1:0] entryQ, updEntry;
  resKind_e         resQ;
  logic [ERR_W-1:0] errQ;

  logic [PA_W-1:0] ctxAddr, tblBase, idxOff, rdAddr, leafOff, leafPa, bypassPa;
  logic            isStore, bootFetch;

  assign isStore   = (accKind_e'(kindQ) == AK_STORE);
  assign bootFetch = bootQ && (accKind_e'(kindQ) == AK_FETCH);

  // read address for the level now being fetched
  assign ctxAddr = {ptrQ & CTX_ALIGN_MASK, 4'b0000} + PA_W'({ctxQ, 2'b00});
  assign tblBase = {entryQ & PTR_MASK, 4'b0000};

  always_comb begin
    case (strb.lvl)
      2'd1:    idxOff = PA_W'({vaQ[31:24], 2'b00});
      2'd2:    idxOff = PA_W'({vaQ[23:18], 2'b00});
      default: idxOff = PA_W'({vaQ[17:12], 2'b00});
    endcase
  end

  assign rdAddr   = (strb.lvl == 2'd0) ? ctxAddr : (tblBase + idxOff);
  assign memAddr  = strb.wrIssue ? walkAddrQ : rdAddr;

  // leaf update
  assign rdType   = memRdata[1:0];
  assign wbNeeded = !memRdata[REF_BIT] || (isStore && !memRdata[MOD_BIT]);
  assign updEntry = entryQ | (ENT_W'(1) << REF_BIT)
                  | (isStore ? (ENT_W'(1) << MOD_BIT) : '0);
  assign memWdata = updEntry;

  // results
  always_comb begin
    case (leafLvlQ)
      2'd1:    leafOff = PA_W'(vaQ[L1_OFF_W-1:0]);
      2'd2:    leafOff = PA_W'(vaQ[L2_OFF_W-1:0]);
      default: leafOff = PA_W'(vaQ[PG_OFF_W-1:0]);
    endcase
  end

  assign leafPa   = {entryQ & PPN_MASK, 4'b0000} + leafOff;
  assign bypassPa = bootFetch ? (promQ | PA_W'(vaQ[ROM_OFF_W-1:0])) : PA_W'(vaQ);

  always_comb begin
    pte     = '0;
    paddr   = '0;
    errCode = '0;
    prot    = '0;
    case (resQ)
      RES_BYPASS: begin
        paddr = bypassPa;
        prot  = bootFetch ? 3'b101 : 3'b111;
      end
      RES_LEAF: begin
        pte   = entryQ;
        paddr = leafPa;
      end
      RES_ERR: errCode = errQ;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ       <= '0;
      ptrQ      <= '0;
      kindQ     <= '0;
      ctxQ      <= '0;
      bootQ     <= 1'b0;
      promQ     <= '0;
      walkAddrQ <= '0;
      entryQ    <= '0;
      leafLvlQ  <= '0;
      errQ      <= '0;
      resQ      <= RES_NONE;
    end else begin
      if (strb.capture) begin
        vaQ   <= reqVa;
        ptrQ  <= ctxTblPtr;
        kindQ <= reqKind;
        ctxQ  <= ctxNum;
        bootQ <= bootMode;
        promQ <= promBase;
        resQ  <= RES_NONE;
      end
      if (strb.rdIssue) walkAddrQ <= rdAddr;
      if (memRvalid)         entryQ <= memRdata;
      else if (strb.wrIssue) entryQ <= updEntry;
      if (strb.setBypass) resQ <= RES_BYPASS;
      if (strb.setLeaf) begin
        resQ     <= RES_LEAF;
        leafLvlQ <= strb.lvl;
      end
      if (strb.setErr) begin
        resQ <= RES_ERR;
        errQ <= {strb.lvl, 3'b000, (strb.errTranslation ? 3'd4 : 3'd1), 2'b00};
      end
    end
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int CTX_W = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [1:0]        reqKind,
  input  logic [VA_W-1:0]   ctxTblPtr,
  input  logic [CTX_W-1:0]  ctxNum,
  input  logic              xlatEn,
  input  logic              bootMode,
  input  logic [PA_W-1:0]   promBase,
  output logic              memReq,
  output logic              memWe,
  output logic [PA_W-1:0]   memAddr,
  output logic [ENT_W-1:0]  memWdata,
  input  logic              memRvalid,
  input  logic [ENT_W-1:0]  memRdata,
  output logic              done,
  output logic [ENT_W-1:0]  pte,
  output logic [PA_W-1:0]   paddr,
  output logic [ERR_W-1:0]  errCode,
  output logic [PROT_W-1:0] prot
);
  walkStrobe_t strb;
  logic [1:0]  rdType;
  logic        wbNeeded;

  pgwalk_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .xlatEn    (xlatEn),
    .rdType    (rdType),
    .wbNeeded  (wbNeeded),
    .memRvalid (memRvalid),
    .strb      (strb),
    .memReq    (memReq),
    .memWe     (memWe),
    .done      (done)
  );

  pgwalk_dp #(.CTX_W(CTX_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqVa     (reqVa),
    .reqKind   (reqKind),
    .ctxTblPtr (ctxTblPtr),
    .ctxNum    (ctxNum),
    .bootMode  (bootMode),
    .promBase  (promBase),
    .memRvalid (memRvalid),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .rdType    (rdType),
    .wbNeeded  (wbNeeded),
    .pte       (pte),
    .paddr     (paddr),
    .errCode   (errCode),
    .prot      (prot)
  );
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk
  import pgwalk_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic [PA_W-1:0]   memAddr,
  input logic              wrRefBit,
  input logic              memRvalid,
  input logic              done,
  input logic [ENT_W-1:0]  pte,
  input logic [PA_W-1:0]   paddr,
  input logic [ERR_W-1:0]  errCode,
  input logic [PROT_W-1:0] prot
);
  logic            rdPend;
  logic [PA_W-1:0] lastRdAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPend     <= 1'b0;
      lastRdAddr <= '0;
    end else begin
      if (memReq && !memWe) begin
        rdPend     <= 1'b1;
        lastRdAddr <= memAddr;
      end else if (memRvalid) begin
        rdPend <= 1'b0;
      end
    end
  end

  // R3
  single_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !rdPend);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  wb_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (wrRefBit && memAddr == lastRdAddr));

  // R13
  err_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && errCode != '0) |-> (paddr == '0 && pte == '0 && prot == '0));

  // R8
  err_fmt_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (errCode[1:0] == 2'b00 && errCode[7:5] == 3'b000 &&
              (errCode[4:2] == 3'd0 || errCode[4:2] == 3'd1 || errCode[4:2] == 3'd4)));

  // R11
  quiet_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);
endmodule

bind pgwalk_top pgwalk_chk u_pgwalk_chk (
  .clk       (clk),
  .rstN      (rstN),
  .memReq    (memReq),
  .memWe     (memWe),
  .memAddr   (memAddr),
  .wrRefBit  (memWdata[5]),
  .memRvalid (memRvalid),
  .done      (done),
  .pte       (pte),
  .paddr     (paddr),
  .errCode   (errCode),
  .prot      (prot)
);

// File: tb/test_pgwalk_top.sv
module test_pgwalk_top;
  localparam int CTX_W = 8;
  localparam logic [31:0] CTX_PTR = 32'h0000_103F;
  localparam logic [35:0] PROM    = 36'h8_FFF0_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVa = '0;
  logic [1:0]  reqKind = '0;
  logic [31:0] ctxTblPtr = CTX_PTR;
  logic [7:0]  ctxNum = '0;
  logic        xlatEn = 1'b0;
  logic        bootMode = 1'b0;
  logic [35:0] promBase = PROM;
  logic        memReq, memWe, done;
  logic [35:0] memAddr, paddr;
  logic [31:0] memWdata, pte;
  logic        memRvalid = 1'b0;
  logic [31:0] memRdata = '0;
  logic [9:0]  errCode;
  logic [2:0]  prot;

  always #10 clk = ~clk;

  pgwalk_top #(.CTX_W(CTX_W)) i_pgwalk_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVa(reqVa), .reqKind(reqKind),
    .ctxTblPtr(ctxTblPtr), .ctxNum(ctxNum), .xlatEn(xlatEn), .bootMode(bootMode),
    .promBase(promBase), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRvalid(memRvalid), .memRdata(memRdata), .done(done),
    .pte(pte), .paddr(paddr), .errCode(errCode), .prot(prot)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // memory model
  logic [31:0] mem [logic [35:0]];
  int          rdN = 0;
  int          wrN = 0;
  logic [35:0] rdLog [8];
  logic [35:0] wrAddrLast;
  logic [31:0] wrDataLast;
  logic [35:0] rdAddrQ = '0;
  int          rdWait = 0;
  int          latSel = 0;

  function automatic logic [31:0] memRead(input logic [35:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    memRvalid <= 1'b0;
    if (rdWait != 0) begin
      if (rdWait == 1) begin
        memRvalid <= 1'b1;
        memRdata  <= memRead(rdAddrQ);
      end
      rdWait <= rdWait - 1;
    end
    if (memReq) begin
      if (memWe) begin
        mem[memAddr] = memWdata;
        wrAddrLast = memAddr;
        wrDataLast = memWdata;
        wrN = wrN + 1;
      end else begin
        rdAddrQ <= memAddr;
        rdWait  <= 1 + (latSel % 3);
        latSel = latSel + 1;
        if (rdN < 8) rdLog[rdN] = memAddr;
        rdN = rdN + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // expected table addresses, computed arithmetically
  function automatic logic [35:0] entAddr(input int lvl, input logic [31:0] va, input logic [7:0] ctx);
    case (lvl)
      0:       return 36'h1_0000 + 36'(ctx) * 4;
      1:       return 36'h2_0000 + 36'(va / 32'h0100_0000) * 4;
      2:       return 36'h3_0000 + 36'((va / 32'h0004_0000) % 64) * 4;
      default: return 36'h4_0000 + 36'((va / 32'h0000_1000) % 64) * 4;
    endcase
  endfunction

  task automatic placePath(input logic [31:0] va, input logic [7:0] ctx, input int depth, input logic [31:0] last);
    for (int l = 0; l < depth; l++)
      mem[entAddr(l, va, ctx)] = 32'h0000_2001 + 32'(l) * 32'h1000;
    mem[entAddr(depth, va, ctx)] = last;
  endtask

  int          nDone;
  logic [31:0] oPte;
  logic [35:0] oPa;
  logic [9:0]  oErr;
  logic [2:0]  oProt;

  task automatic doWalk(input logic [31:0] va, input logic [1:0] kind, input logic [7:0] ctx,
                        input bit xen, input bit boot, input bit intrude);
    rdN = 0;
    wrN = 0;
    nDone = 0;
    @(negedge clk);
    reqValid = 1'b1; reqVa = va; reqKind = kind; ctxNum = ctx; xlatEn = xen; bootMode = boot;
    @(negedge clk);
    reqValid = 1'b0;
    for (int c = 0; c < 60; c++) begin
      if (intrude && c >= 1 && c <= 3) begin
        reqValid = 1'b1; reqVa = ~va; xlatEn = 1'b0; reqKind = 2'd1;
      end else begin
        reqValid = 1'b0;
      end
      if (done) begin
        nDone++;
        oPte = pte; oPa = paddr; oErr = errCode; oProt = prot;
      end
      @(negedge clk);
    end
    reqValid = 1'b0;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done in reset", 36'(done), 36'h0);
    rstN = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(done == 1'b0 && memReq == 1'b0, "R1 idle after reset", 36'({done, memReq}), 36'h0);
    end

    // R11 R12: pass-through sweep
    for (int b = 0; b < 2; b++) begin
      for (int k = 0; k < 3; k++) begin
        logic [31:0] va;
        logic [35:0] exPa;
        logic [2:0]  exProt;
        va = 32'hC0DE_1234 + 32'(b * 3 + k) * 32'h0107_3F31;
        if (b == 1 && k == 2) begin
          exPa = PROM | 36'(va % 32'h0008_0000);
          exProt = 3'b101;
        end else begin
          exPa = 36'(va);
          exProt = 3'b111;
        end
        doWalk(va, 2'(k), 8'd3, 1'b0, 1'(b), 1'b0);
        chk(nDone == 1, "R2 bypass one done", 36'(nDone), 36'd1);
        chk(oPa == exPa, (b == 1 && k == 2) ? "R12 boot paddr" : "R11 bypass paddr", oPa, exPa);
        chk(oProt == exProt, (b == 1 && k == 2) ? "R12 boot prot" : "R11 bypass prot", 36'(oProt), 36'(exProt));
        chk(rdN == 0 && wrN == 0, "R11 no memory access", 36'(rdN + wrN), 36'h0);
        chk(oPte == 32'h0 && oErr == 10'h0, "R11 pte and err zero", 36'({oPte, oErr}), 36'h0);
      end
    end

    // R4 R5 R6 R7 R9 R10: leaf sweep over level, ref/mod bits and access kind
    for (int d = 1; d <= 3; d++) begin
      for (int rm = 0; rm < 4; rm++) begin
        for (int k = 0; k < 3; k++) begin
          logic [31:0] va, ent, exPte;
          logic [7:0]  ctx;
          logic [35:0] exPa, offMask, leafA;
          bit          needWb;
          va  = 32'h9E37_79B9 * 32'(d * 12 + rm * 3 + k + 1);
          ctx = 8'((d * 37 + rm * 11 + k * 5) % 256);
          if (d == 3 && rm == 3 && k == 2) ctx = 8'd255;
          ent = (32'h0123_4500 + 32'(d) * 32'h0001_0000 + 32'(k) * 32'h100)
              | ((rm % 2) != 0 ? 32'h20 : 32'h0) | ((rm / 2) != 0 ? 32'h40 : 32'h0) | 32'h1C | 32'h2;
          placePath(va, ctx, d, ent);
          leafA   = entAddr(d, va, ctx);
          offMask = (d == 1) ? 36'hFF_FFFF : (d == 2) ? 36'h3_FFFF : 36'hFFF;
          exPa    = (36'(ent & 32'hFFFF_FF00) * 16) + (36'(va) & offMask);
          needWb  = ((rm % 2) == 0) || (k == 1 && (rm / 2) == 0);
          exPte   = ent | 32'h20 | ((k == 1) ? 32'h40 : 32'h0);
          doWalk(va, 2'(k), ctx, 1'b1, 1'b0, 1'b0);
          chk(nDone == 1, "R2 one done per walk", 36'(nDone), 36'd1);
          chk(rdN == d + 1, "R6 reads per walk", 36'(rdN), 36'(d + 1));
          chk(rdLog[0] == entAddr(0, va, ctx), "R4 context entry address", rdLog[0], entAddr(0, va, ctx));
          for (int l = 1; l <= d; l++)
            chk(rdLog[l] == entAddr(l, va, ctx), "R5 level entry address", rdLog[l], entAddr(l, va, ctx));
          chk(oPa == exPa, "R7 leaf paddr", oPa, exPa);
          chk(oErr == 10'h0 && oProt == 3'b0, "R13 leaf err and prot zero", 36'({oErr, oProt}), 36'h0);
          chk(oPte == exPte, "R9 leaf pte", 36'(oPte), 36'(exPte));
          if (needWb) begin
            chk(wrN == 1, "R9 write-back issued", 36'(wrN), 36'd1);
            chk(memRead(leafA) == exPte, "R9 written entry", 36'(memRead(leafA)), 36'(exPte));
          end else begin
            chk(wrN == 0, "R10 no write-back", 36'(wrN), 36'd0);
            chk(memRead(leafA) == ent, "R10 entry unchanged", 36'(memRead(leafA)), 36'(ent));
          end
        end
      end
    end

    // R8 R13: error sweep over level and entry type
    begin
      int eD [10] = '{0, 0, 0, 1, 1, 2, 2, 3, 3, 3};
      int eT [10] = '{0, 2, 3, 0, 3, 0, 3, 0, 1, 3};
      for (int i = 0; i < 10; i++) begin
        logic [31:0] va;
        logic [7:0]  ctx;
        logic [9:0]  exErr;
        va  = 32'h7F3A_5C00 + 32'(i) * 32'h0345_7000;
        ctx = (i == 0) ? 8'd255 : 8'(i * 19);
        placePath(va, ctx, eD[i], 32'h00AB_CD00 | 32'(eT[i]));
        exErr = 10'(eD[i] * 256 + ((eT[i] == 0) ? 1 : 4) * 4);
        doWalk(va, 2'(i % 3), ctx, 1'b1, 1'b0, 1'b0);
        chk(nDone == 1, "R2 one done on error", 36'(nDone), 36'd1);
        chk(oErr == exErr, "R8 error code", 36'(oErr), 36'(exErr));
        chk(oPa == 36'h0 && oPte == 32'h0 && oProt == 3'b0, "R13 outputs zero on error",
            oPa | 36'(oPte) | 36'(oProt), 36'h0);
        chk(rdN == eD[i] + 1 && wrN == 0, "R3 reads on error walk", 36'(rdN * 16 + wrN), 36'((eD[i] + 1) * 16));
      end
    end

    // R2: request during a walk is ignored
    begin
      logic [31:0] va, ent;
      logic [35:0] exPa;
      va  = 32'h1357_9BDF;
      ent = 32'h0055_6600 | 32'h60 | 32'h2;
      placePath(va, 8'd9, 3, ent);
      exPa = (36'(ent & 32'hFFFF_FF00) * 16) + (36'(va) & 36'hFFF);
      doWalk(va, 2'd0, 8'd9, 1'b1, 1'b0, 1'b1);
      chk(nDone == 1, "R2 single done with busy request", 36'(nDone), 36'd1);
      chk(oPa == exPa, "R2 busy request left walk intact", oPa, exPa);
      chk(rdN == 4 && wrN == 0, "R2 no extra accesses", 36'(rdN * 16 + wrN), 36'd64);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule